// File: doc/BRIEF.md
# Pipeline Operand Bypass Unit

This block decides, for every source operand of the decode and execute stages of a five-stage integer pipeline, whether the operand should come from the register file or from a result that is still moving through the later pipeline registers. It compares source register numbers against the destination numbers and write enables held in the execute/memory (XM) and memory/writeback (MW) pipeline registers. It reports a 2-bit select code for each operand and drives the bypassed operand data. The register file is part of the block. A writeback in a given cycle is visible to a decode read in that same cycle, so a result reaches the third instruction after its producer without waiting.

The two decode operands feed the branch comparison, so they are bypassed as well as the two execute-stage ALU operands. Two producer kinds are handled. An ALU result can be forwarded from XM. Loaded data exists only after the memory stage, so it can come only from MW or later. Stall generation is outside this block. When a load in XM matches a source, the operand falls back to the older paths, and the stall logic around the block must hold the consumer.

Top module: `opnd_bypass`

## Requirements
- R1: When XM writes (xm_wr_en=1), is not a load (xm_load=0), has xm_rd not 0 and xm_rd equals an execute source, that operand's select is 2'b10 and its data is xm_alu_res.
- R2: When R1 does not apply to an execute source, and MW writes (mw_wr_en=1) with mw_rd not 0 equal to that source, the select is 2'b01 and the data is mw_data.
- R3: When both XM and MW match a source and XM qualifies under R1, the younger XM result wins (select 2'b10).
- R4: A load in XM (xm_load=1) never forwards from XM. The operand takes the MW path if MW matches, otherwise the register-file path.
- R5: A destination of register 0 never forwards. A decode read of register 0 returns zero, and a write to register 0 has no effect.
- R6: Decode sources id_rs_a and id_rs_b follow the same select rules as R1 to R4. Their data is xm_alu_res for select 2'b10, and otherwise the register-file read data.
- R7: A register-file read of the register that MW writes in the same cycle returns mw_data. From the next clock edge the register holds that value.
- R8: Reset (rst_n=0, asynchronous) clears every register to zero.
- R9: With no qualifying match the select is 2'b00. An execute operand then passes ex_val_a or ex_val_b, and a decode operand passes the stored register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs_a | input | AW | Decode source register A |
| id_rs_b | input | AW | Decode source register B |
| ex_rs_a | input | AW | Execute source register A |
| ex_rs_b | input | AW | Execute source register B |
| ex_val_a | input | XLEN | Operand A value latched at decode |
| ex_val_b | input | XLEN | Operand B value latched at decode |
| xm_wr_en | input | 1 | XM instruction writes a register |
| xm_load | input | 1 | XM instruction is a load |
| xm_rd | input | AW | XM destination register |
| xm_alu_res | input | XLEN | XM ALU result |
| mw_wr_en | input | 1 | MW instruction writes a register (writeback enable) |
| mw_rd | input | AW | MW destination register |
| mw_data | input | XLEN | MW writeback data (ALU result or loaded data) |
| id_sel_a | output | 2 | Decode operand A select: 00 RF, 01 MW, 10 XM |
| id_sel_b | output | 2 | Decode operand B select |
| ex_sel_a | output | 2 | Execute operand A select |
| ex_sel_b | output | 2 | Execute operand B select |
| id_opnd_a | output | XLEN | Bypassed decode operand A |
| id_opnd_b | output | XLEN | Bypassed decode operand B |
| ex_opnd_a | output | XLEN | Bypassed execute operand A |
| ex_opnd_b | output | XLEN | Bypassed execute operand B |

## Verification
The bench sweeps every combination of XM and MW destination over registers 0 to 7, every XM/MW write-enable and load flag, and every source number in that range. Each of the four operands sees a different source, and the bench checks the select code and the data for each one. This separates the youngest-wins order from the MW-only case and load suppression from a plain ALU forward. It also separates the register-0 rule from an ordinary miss. A reference register image kept in the bench tracks every writeback. A separate write phase shows that same-cycle write-through and the stored value after the edge agree, and that reset clears the file.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;
  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_MW = 2'b01,
    SEL_XM = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/opnd_regfile.sv
module opnd_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr [NRD],
  output logic [XLEN-1:0] rd_data [NRD]
);
  logic [XLEN-1:0] mem_q [NREG];
  logic [NREG-1:0] ent_en;

  // per-entry clock enable; entry 0 is never written
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      ent_en[i] = wr_en && (wr_addr == AW'(i)) && (i != 0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (ent_en[i]) mem_q[i] <= wr_data;
      end
    end
  end

  // read ports with same-cycle write-through
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_addr[p] == '0)
        rd_data[p] = '0;
      else if (wr_en && (wr_addr == rd_addr[p]))
        rd_data[p] = wr_data;
      else
        rd_data[p] = mem_q[rd_addr[p]];
    end
  end
endmodule

// File: rtl/opnd_fwd_select.sv
module opnd_fwd_select
  import opnd_bypass_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic      [AW-1:0] src,
  input  logic               xm_wr_en,
  input  logic               xm_load,
  input  logic      [AW-1:0] xm_rd,
  input  logic               mw_wr_en,
  input  logic      [AW-1:0] mw_rd,
  output opnd_sel_e          sel
);
  logic xm_hit;
  logic mw_hit;

  always_comb begin
    xm_hit = xm_wr_en && !xm_load && (xm_rd != '0) && (xm_rd == src);
    mw_hit = mw_wr_en && (mw_rd != '0) && (mw_rd == src);
    if (xm_hit)      sel = SEL_XM;
    else if (mw_hit) sel = SEL_MW;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import opnd_bypass_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   id_rs_a,
  input  logic [AW-1:0]   id_rs_b,
  input  logic [AW-1:0]   ex_rs_a,
  input  logic [AW-1:0]   ex_rs_b,
  input  logic [XLEN-1:0] ex_val_a,
  input  logic [XLEN-1:0] ex_val_b,
  input  logic            xm_wr_en,
  input  logic            xm_load,
  input  logic [AW-1:0]   xm_rd,
  input  logic [XLEN-1:0] xm_alu_res,
  input  logic            mw_wr_en,
  input  logic [AW-1:0]   mw_rd,
  input  logic [XLEN-1:0] mw_data,
  output logic [1:0]      id_sel_a,
  output logic [1:0]      id_sel_b,
  output logic [1:0]      ex_sel_a,
  output logic [1:0]      ex_sel_b,
  output logic [XLEN-1:0] id_opnd_a,
  output logic [XLEN-1:0] id_opnd_b,
  output logic [XLEN-1:0] ex_opnd_a,
  output logic [XLEN-1:0] ex_opnd_b
);
  localparam int NOPND = 4;   // 0,1 decode; 2,3 execute
  localparam int NID   = 2;

  logic [AW-1:0]   src   [NOPND];
  opnd_sel_e       sel   [NOPND];
  logic [XLEN-1:0] rf_rd [NID];
  logic [XLEN-1:0] latch [NID];
  logic [XLEN-1:0] opnd  [NOPND];

  assign src[0]   = id_rs_a;
  assign src[1]   = id_rs_b;
  assign src[2]   = ex_rs_a;
  assign src[3]   = ex_rs_b;
  assign latch[0] = ex_val_a;
  assign latch[1] = ex_val_b;

  opnd_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NID)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mw_wr_en),
    .wr_addr (mw_rd),
    .wr_data (mw_data),
    .rd_addr (src[0:NID-1]),
    .rd_data (rf_rd)
  );

  for (genvar k = 0; k < NOPND; k++) begin : g_sel
    opnd_fwd_select #(.AW(AW)) u_sel (
      .src      (src[k]),
      .xm_wr_en (xm_wr_en),
      .xm_load  (xm_load),
      .xm_rd    (xm_rd),
      .mw_wr_en (mw_wr_en),
      .mw_rd    (mw_rd),
      .sel      (sel[k])
    );

    if (k < NID) begin : g_id
      // MW data arrives through the register file write-through path
      always_comb begin
        if (sel[k] == SEL_XM) opnd[k] = xm_alu_res;
        else                  opnd[k] = rf_rd[k];
      end
    end else begin : g_ex
      always_comb begin
        unique case (sel[k])
          SEL_XM:  opnd[k] = xm_alu_res;
          SEL_MW:  opnd[k] = mw_data;
          default: opnd[k] = latch[k-NID];
        endcase
      end
    end
  end

  assign id_sel_a  = sel[0];
  assign id_sel_b  = sel[1];
  assign ex_sel_a  = sel[2];
  assign ex_sel_b  = sel[3];
  assign id_opnd_a = opnd[0];
  assign id_opnd_b = opnd[1];
  assign ex_opnd_a = opnd[2];
  assign ex_opnd_b = opnd[3];
endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   id_rs_a,
  input logic [AW-1:0]   ex_rs_a,
  input logic [AW-1:0]   ex_rs_b,
  input logic [XLEN-1:0] ex_val_a,
  input logic            xm_wr_en,
  input logic            xm_load,
  input logic [AW-1:0]   xm_rd,
  input logic [XLEN-1:0] xm_alu_res,
  input logic            mw_wr_en,
  input logic [AW-1:0]   mw_rd,
  input logic [XLEN-1:0] mw_data,
  input logic [1:0]      ex_sel_a,
  input logic [1:0]      ex_sel_b,
  input logic [XLEN-1:0] id_opnd_a,
  input logic [XLEN-1:0] ex_opnd_a
);
  a_r1_xm_alu_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (xm_wr_en && !xm_load && xm_rd != '0 && xm_rd == ex_rs_a) |-> ex_opnd_a == xm_alu_res);

  a_r4_load_not_xm: assert property (@(posedge clk) disable iff (!rst_n)
    xm_load |-> (ex_sel_a != 2'b10 && ex_sel_b != 2'b10));

  a_r5_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs_a == '0) |-> id_opnd_a == '0);

  a_r9_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!(xm_wr_en && xm_rd == ex_rs_a) && !(mw_wr_en && mw_rd == ex_rs_a)) |-> ex_opnd_a == ex_val_a);

  a_r7_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_wr_en && mw_rd != '0) |=>
      ((id_rs_a == $past(mw_rd) && !(mw_wr_en && mw_rd == id_rs_a)
        && !(xm_wr_en && !xm_load && xm_rd == id_rs_a))
       ? id_opnd_a == $past(mw_data) : 1'b1));

  a_r2_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ex_sel_a) && $onehot0(ex_sel_b));
endmodule

bind opnd_bypass opnd_bypass_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk, .rst_n, .id_rs_a, .ex_rs_a, .ex_rs_b, .ex_val_a, .xm_wr_en, .xm_load,
  .xm_rd, .xm_alu_res, .mw_wr_en, .mw_rd, .mw_data, .ex_sel_a, .ex_sel_b,
  .id_opnd_a, .ex_opnd_a
);

// File: tb/opnd_bypass_bench.sv
`timescale 1ns/1ps
module opnd_bypass_bench;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] id_rs_a, id_rs_b, ex_rs_a, ex_rs_b, xm_rd, mw_rd;
  logic [XLEN-1:0] ex_val_a, ex_val_b, xm_alu_res, mw_data;
  logic xm_wr_en, xm_load, mw_wr_en;
  logic [1:0] id_sel_a, id_sel_b, ex_sel_a, ex_sel_b;
  logic [XLEN-1:0] id_opnd_a, id_opnd_b, ex_opnd_a, ex_opnd_b;

  int total = 0;
  int bad = 0;
  logic [XLEN-1:0] model [NREG];

  always #4 clk = ~clk;

  opnd_bypass #(.XLEN(XLEN), .NREG(NREG)) u_opnd_bypass (.*);

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
    if (xm_wr_en && !xm_load && xm_rd != 0 && xm_rd == s) return 2'b10;
    if (mw_wr_en && mw_rd != 0 && mw_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_of(input logic [AW-1:0] s);
    logic [1:0] e;
    e = exp_sel(s);
    if (e == 2'b10) return (mw_wr_en && mw_rd == s && s != 0) ? "R3" : "R1";
    if (e == 2'b01) return (xm_wr_en && xm_load && xm_rd == s) ? "R4" : "R2";
    if (s == 0) return "R5";
    if (xm_wr_en && xm_load && xm_rd == s) return "R4";
    return "R9";
  endfunction

  function automatic logic [XLEN-1:0] exp_ex(input logic [AW-1:0] s, input logic [XLEN-1:0] v);
    case (exp_sel(s))
      2'b10:   return xm_alu_res;
      2'b01:   return mw_data;
      default: return v;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] exp_id(input logic [AW-1:0] s);
    case (exp_sel(s))
      2'b10:   return xm_alu_res;
      2'b01:   return mw_data;
      default: return (s == 0) ? '0 : model[s];
    endcase
  endfunction

  task automatic idle();
    id_rs_a = '0; id_rs_b = '0; ex_rs_a = '0; ex_rs_b = '0;
    ex_val_a = '0; ex_val_b = '0; xm_wr_en = 1'b0; xm_load = 1'b0;
    xm_rd = '0; xm_alu_res = '0; mw_wr_en = 1'b0; mw_rd = '0; mw_data = '0;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: file reads zero after reset
    for (int r = 1; r < 8; r++) begin
      @(negedge clk);
      id_rs_a = AW'(r);
      #1 chk("R8", id_opnd_a, '0);
    end

    // R7: write-through then held; R5: register 0 write ignored
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      mw_wr_en = 1'b1; mw_rd = AW'(r); mw_data = 32'h5A00_0000 + r * 32'h111;
      id_rs_a = AW'(r); id_rs_b = AW'(r);
      #1;
      if (r == 0) chk("R5", id_opnd_a, '0);
      else        chk("R7", id_opnd_b, mw_data);
      @(posedge clk);
      #1;
      if (r != 0) model[r] = mw_data;
      @(negedge clk);
      mw_wr_en = 1'b0; mw_data = '1;
      #1;
      if (r == 0) chk("R5", id_opnd_a, '0);
      else        chk("R7", id_opnd_a, model[r]);
    end

    // sweep: R1 R2 R3 R4 R5 R6 R9
    for (int it = 0; it < 4096; it++) begin
      @(negedge clk);
      xm_rd    = AW'(it & 7);
      mw_rd    = AW'((it >> 3) & 7);
      xm_wr_en = it[6];
      mw_wr_en = it[7];
      xm_load  = it[8];
      id_rs_a  = AW'((it >> 9) & 7);
      id_rs_b  = AW'(((it >> 9) + 3) & 7);
      ex_rs_a  = AW'(((it >> 9) + 1) & 7);
      ex_rs_b  = AW'(((it >> 9) + 5) & 7);
      xm_alu_res = 32'hB000_0000 + it;
      mw_data    = 32'hA000_0000 + it;
      ex_val_a   = 32'hC000_0000 + it;
      ex_val_b   = 32'hD000_0000 + it;
      #2;
      chk({tag_of(ex_rs_a), " ex_sel_a"}, {30'd0, ex_sel_a}, {30'd0, exp_sel(ex_rs_a)});
      chk({tag_of(ex_rs_b), " ex_sel_b"}, {30'd0, ex_sel_b}, {30'd0, exp_sel(ex_rs_b)});
      chk({tag_of(ex_rs_a), " ex_opnd_a"}, ex_opnd_a, exp_ex(ex_rs_a, ex_val_a));
      chk({tag_of(ex_rs_b), " ex_opnd_b"}, ex_opnd_b, exp_ex(ex_rs_b, ex_val_b));
      chk("R6 id_sel_a", {30'd0, id_sel_a}, {30'd0, exp_sel(id_rs_a)});
      chk("R6 id_sel_b", {30'd0, id_sel_b}, {30'd0, exp_sel(id_rs_b)});
      chk("R6 id_opnd_a", id_opnd_a, exp_id(id_rs_a));
      chk("R6 id_opnd_b", id_opnd_b, exp_id(id_rs_b));
      @(posedge clk);
      #1;
      if (mw_wr_en && mw_rd != 0) model[mw_rd] = mw_data;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule